// File: doc/BRIEF.md
# Row-Column Addressed Bit RAM

This block is a one-bit-wide static memory of 256 cells laid out as a square grid of 16 rows by 16 columns. The address is split into two halves. Each half feeds its own one-hot decoder, and a cell is selected only where its active row line crosses its active column line. Reading is a purely combinational path from the selected cell to the output. Writing loads the selected cell on the rising clock edge.

A chip-enable gates all data movement through the block. This lets several instances share one data wire and be banked behind an external address decoder. The shared wire is modelled as three separate signals: a data input, a data output, and an output-enable that tells the surrounding logic when this instance is driving. One read/write control line is shared by every cell. An active-low reset clears the grid so that simulation starts from a known state.

Top module: `ramBitGrid`

## Requirements
- R1: While reset is held and after it is released, every cell reads as 0 until it is written.
- R2: Address bits [7:4] select the row and bits [3:0] select the column. Each decoder drives exactly one of its 16 lines high. Writing one address leaves the other 255 cells unchanged, including those that share its row or its column.
- R3: Reads are combinational. When chipEn=1 and writeEn=0, dataOut shows the cell at the current address in the same cycle that addr changes, with no clock edge in between.
- R4: On a rising clock edge with chipEn=1 and writeEn=1, dataIn is stored into the addressed cell.
- R5: outEn is 1 exactly when chipEn=1 and writeEn=0.
- R6: Whenever outEn is 0, dataOut is 0, which models a released driver.
- R7: A write request with chipEn=0 leaves every cell unchanged.
- R8: A cell keeps its value across reads and across any number of cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rstN | input | 1 | Active-low reset; clears all cells |
| chipEn | input | 1 | Chip enable; when 0 no data moves in or out |
| writeEn | input | 1 | Shared read/write control: 1 = write, 0 = read |
| addr | input | 8 | Cell address: upper half is the row, lower half is the column |
| dataIn | input | 1 | Bit to be written |
| dataOut | output | 1 | Bit read from the selected cell; 0 when not driving |
| outEn | output | 1 | High while this instance drives the shared data line |

## Verification
The bench builds the block with its default parameters: four row bits and four column bits. At that size every one of the 256 cells can be written and read back within a short run. This allows full-grid sweeps with several data patterns, including a single set bit in an otherwise clear grid, which shows that row and column decoding keep cells apart. Disabled write sweeps and idle stretches then confirm that the stored image does not change.

// File: rtl/ramGridPkg.sv
package ramGridPkg;
  typedef struct packed {
    logic writeCell;
    logic driveOut;
  } ramStrobes_t;
endpackage

// File: rtl/ramGridCtrl.sv
module ramGridCtrl
  import ramGridPkg::*;
(
  input  logic        chipEn,
  input  logic        writeEn,
  output ramStrobes_t strobes
);
  always_comb begin
    strobes.writeCell = chipEn & writeEn;
    strobes.driveOut  = chipEn & ~writeEn;
  end
endmodule

// File: rtl/ramGridPath.sv
module ramGridPath
  import ramGridPkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ROWS   = 1 << ROW_BITS,
  localparam int COLS   = 1 << COL_BITS,
  localparam int ADDR_W = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIn,
  output logic              readBit,
  output logic [ROWS-1:0]   rowSel,
  output logic [COLS-1:0]   colSel
);
  localparam int CELLS = ROWS * COLS;

  logic [ROW_BITS-1:0] rowAddr;
  logic [COL_BITS-1:0] colAddr;
  logic [CELLS-1:0]    cellQ;
  logic [CELLS-1:0]    cellHit;

  assign rowAddr = addr[ADDR_W-1 -: ROW_BITS];
  assign colAddr = addr[COL_BITS-1:0];

  // one-hot decoders, one per address half
  always_comb begin
    rowSel = '0;
    rowSel[rowAddr] = 1'b1;
  end

  always_comb begin
    colSel = '0;
    colSel[colAddr] = 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cellHit[r*COLS+c] = rowSel[r] & colSel[c];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cellQ[r*COLS+c] <= 1'b0;
        else if (strobes.writeCell && cellHit[r*COLS+c])
          cellQ[r*COLS+c] <= dataIn;
      end
    end
  end

  // shared internal sense line: only the crossing cell contributes
  assign readBit = |(cellQ & cellHit);
endmodule

// File: rtl/ramBitGrid.sv
module ramBitGrid
  import ramGridPkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS   = 1 << ROW_BITS,
  localparam int COLS   = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              outEn
);
  ramStrobes_t strobes;
  logic        readBit;
  logic [ROWS-1:0] rowSel;
  logic [COLS-1:0] colSel;

  ramGridCtrl u_ctrl (
    .chipEn  (chipEn),
    .writeEn (writeEn),
    .strobes (strobes)
  );

  ramGridPath #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addr),
    .dataIn  (dataIn),
    .readBit (readBit),
    .rowSel  (rowSel),
    .colSel  (colSel)
  );

  assign outEn   = strobes.driveOut;
  assign dataOut = strobes.driveOut & readBit;
endmodule

// File: rtl/ramBitGridChecker.sv
module ramBitGridChecker #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS   = 1 << ROW_BITS,
  localparam int COLS   = 1 << COL_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEn,
  input logic              writeEn,
  input logic [ADDR_W-1:0] addr,
  input logic              dataIn,
  input logic              dataOut,
  input logic              outEn,
  input logic [ROWS-1:0]   rowSel,
  input logic [COLS-1:0]   colSel
);
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rowSel) == 1); // R2

  AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colSel) == 1); // R2

  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    outEn == (chipEn && !writeEn)); // R5

  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !dataOut); // R6

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(chipEn && writeEn) && chipEn && !writeEn
     && addr == $past(addr)) |-> dataOut == $past(dataIn)); // R4

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(chipEn && writeEn) && $past(outEn) && outEn
     && addr == $past(addr)) |-> dataOut == $past(dataOut)); // R8
endmodule

bind ramBitGrid ramBitGridChecker #(
  .ROW_BITS (ROW_BITS),
  .COL_BITS (COL_BITS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .chipEn  (chipEn),
  .writeEn (writeEn),
  .addr    (addr),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .outEn   (outEn),
  .rowSel  (rowSel),
  .colSel  (colSel)
);

// File: tb/tb_ramBitGrid.sv
module tb_ramBitGrid;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipEn = 1'b0;
  logic       writeEn = 1'b0;
  logic [7:0] addr = '0;
  logic       dataIn = 1'b0;
  logic       dataOut;
  logic       outEn;

  int  total = 0;
  int  bad = 0;
  bit  model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ramBitGrid dut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .writeEn(writeEn),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .outEn(outEn)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (addr=%0h)", req, act, exp, addr);
    end
  endtask

  // drive at negedge, check combinational outputs before the edge,
  // then advance the reference model at the rising edge
  task automatic step(input string req, input bit ce, input bit we,
                      input int a, input bit d);
    bit expOe;
    @(negedge clk);
    chipEn = ce; writeEn = we; addr = 8'(a); dataIn = d;
    #1;
    expOe = ce && !we;
    check("R5", outEn, expOe);
    if (expOe) check(req, dataOut, model[a]);
    else       check("R6", dataOut, 1'b0);
    @(posedge clk);
    if (rstN && ce && we) model[a] = d;
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 256; a++) step(req, 1'b1, 1'b0, a, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) model[a] = 1'b0;
    // R1: reads while reset is held
    step("R1", 1'b1, 1'b0, 8'h3C, 1'b0);
    step("R1", 1'b1, 1'b1, 8'h3C, 1'b1);
    step("R1", 1'b1, 1'b0, 8'h3C, 1'b0);
    @(negedge clk); rstN = 1'b1;
    readAll("R1");

    // R4 with pattern, read back over the grid (R3: same-cycle reads)
    for (int a = 0; a < 256; a++) step("R4", 1'b1, 1'b1, a, bit'(((a * 7) >> 2) & 1));
    readAll("R3");

    // R7: disabled writes of inverted data change nothing
    for (int a = 0; a < 256; a++) step("R7", 1'b0, 1'b1, a, ~model[a]);
    readAll("R7");

    // R8: idle stretch, then repeated reads
    for (int i = 0; i < 20; i++) step("R8", 1'b0, 1'b0, i * 13, 1'b1);
    for (int i = 0; i < 4; i++) readAll("R8");

    // R2: single set bit in cleared grid
    for (int a = 0; a < 256; a++) step("R4", 1'b1, 1'b1, a, 1'b0);
    step("R2", 1'b1, 1'b1, 8'h5A, 1'b1);
    readAll("R2");
    step("R2", 1'b1, 1'b1, 8'hA5, 1'b1);
    step("R2", 1'b1, 1'b1, 8'h5A, 1'b0);
    readAll("R2");

    // R4: alternating pattern, checkerboard
    for (int a = 0; a < 256; a++) step("R4", 1'b1, 1'b1, a, bit'((a ^ (a >> 4)) & 1));
    readAll("R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule